// File: doc/BRIEF.md
# Ordered Store Buffer with Fences

This block sits between the load/store port of a single processor and one word-wide memory port. Accepted stores are not sent to memory at once. They go into a small circular buffer and leave it strictly oldest first. A load whose address matches no buffered store may reach memory ahead of those older stores, which gives total-store-order style reordering. A load whose address matches a buffered store is answered from the buffer. Three fence requests let software restore ordering where it needs it: a load fence, a store fence and a full fence.

The processor side is one request channel with a valid/ready handshake. A 3-bit kind field selects load, store or one of the fences. A fence completes when it is accepted, so the block holds `req_ready` low until the fence condition is met. Load data returns on a separate response strobe in program order. The memory side takes at most one access per cycle, on `mem_valid && mem_ready`. Read data comes back later on `mem_rvalid`. The memory must accept only one read at a time and return its data at least one cycle after the read is accepted. The block re-decides its memory request in every cycle, and an access counts only in the cycle it is taken.

Top module: `ordered_store_buffer`

## Requirements
- R1: `req_kind` encodes 0 = load, 1 = store, 2 = load fence, 3 = store fence, 4 to 7 = full fence. A store is accepted whenever fewer than 4 stores are buffered. While 4 are buffered, `req_ready` stays low for a store request.
- R2: Every accepted store is written to memory exactly once (`mem_we` = 1), in acceptance order, with the address and data it carried.
- R3: A load whose address matches no buffered store is issued as a memory read even while older stores wait in the buffer. When both want the port, the load wins unless the oldest store has waited 8 cycles.
- R4: A load whose address matches a buffered store issues no memory read. It is answered with `rsp_valid` in the cycle after acceptance, carrying the data of the youngest matching store.
- R5: Load responses appear in acceptance order, and each carries the value of the latest earlier store to that word, or the memory contents if there is none. At most one memory read is outstanding, and no load is accepted while a read is outstanding.
- R6: A load fence is accepted only when no memory read is outstanding, so every earlier load has returned its data.
- R7: A store fence is accepted only when the buffer is empty, so every earlier store has been written to memory.
- R8: A full fence is accepted only when both the load fence and the store fence conditions hold.
- R9: Once the oldest buffered store has waited 8 cycles without being written, it takes the memory port before a pending load that misses the buffer.
- R10: After reset there is no memory request and no response, and a store request sees `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted in this cycle |
| req_kind | input | 3 | Request kind (see R1) |
| req_addr | input | AW | Word address of a load or store |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | DW | Load data |
| mem_valid | output | 1 | Memory access requested |
| mem_ready | input | 1 | Memory takes the access in this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | DW | Read data |

## Verification
The hardest situations to reach are a load passing stores that are stuck in the buffer, and the moment when the oldest of those stores has waited long enough to take the port back. The bench memory can refuse writes while still serving reads. With writes refused, the bench fills the buffer, sends loads that miss it and loads that hit it, and holds fences. It then lets a store age past the 8-cycle limit while a load waits, releases writes, and reads back the order in which memory saw the accesses. A long phase of mixed random traffic, with random ready and read latency, then checks every write and every response against a program-order model.

// File: rtl/ordered_store_buffer.sv
module ordered_store_buffer #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DEPTH  = 4,
  parameter int STARVE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int GW = $clog2(STARVE + 1);

  localparam logic [2:0] K_LOAD   = 3'd0;
  localparam logic [2:0] K_STORE  = 3'd1;
  localparam logic [2:0] K_LFENCE = 3'd2;
  localparam logic [2:0] K_SFENCE = 3'd3;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [AW-1:0] buf_addr [DEPTH];
  logic [DW-1:0] buf_data [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;
  logic [GW-1:0] age_q;
  logic          rd_busy_q;
  logic          fwd_q;
  logic [DW-1:0] fwd_data_q;

  logic          hit;
  logic [DW-1:0] hit_data;
  logic          empty, full, starved;
  logic          is_load, load_cand, fwd_take;
  logic          gnt_store, gnt_load;
  logic          push, drain, issue;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CW'(DEPTH));
  assign starved = (age_q >= GW'(STARVE));
  assign is_load = req_valid && (req_kind == K_LOAD);

  always_comb begin
    int j;
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      j = (int'(head_q) + i) % DEPTH;
      if (i < int'(count_q) && buf_addr[PW'(j)] == req_addr) begin
        hit      = 1'b1;
        hit_data = buf_data[PW'(j)];
      end
    end
  end

  assign load_cand = is_load && !rd_busy_q && !hit;
  assign fwd_take  = is_load && !rd_busy_q && hit;
  assign gnt_store = !empty && (!load_cand || starved);
  assign gnt_load  = load_cand && !gnt_store;

  assign mem_valid = gnt_store || gnt_load;
  assign mem_we    = gnt_store;
  assign mem_addr  = gnt_store ? buf_addr[head_q] : req_addr;
  assign mem_wdata = buf_data[head_q];

  assign drain = mem_valid && mem_ready && mem_we;
  assign issue = mem_valid && mem_ready && !mem_we;

  always_comb begin
    case (req_kind)
      K_LOAD:   req_ready = !rd_busy_q && (hit || issue);
      K_STORE:  req_ready = !full;
      K_LFENCE: req_ready = !rd_busy_q;
      K_SFENCE: req_ready = empty;
      default:  req_ready = empty && !rd_busy_q;
    endcase
  end

  assign push = req_valid && (req_kind == K_STORE) && !full;

  assign rsp_valid = fwd_q || (rd_busy_q && mem_rvalid);
  assign rsp_rdata = fwd_q ? fwd_data_q : mem_rdata;

  always_ff @(posedge clk) begin
    if (push) begin
      buf_addr[tail_q] <= req_addr;
      buf_data[tail_q] <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= '0;
      count_q    <= '0;
      age_q      <= '0;
      rd_busy_q  <= 1'b0;
      fwd_q      <= 1'b0;
      fwd_data_q <= '0;
    end else begin
      if (push)  tail_q <= step(tail_q);
      if (drain) head_q <= step(head_q);
      count_q <= count_q + CW'(push) - CW'(drain);
      if (empty || drain)  age_q <= '0;
      else if (!starved)   age_q <= age_q + 1'b1;
      if (issue)           rd_busy_q <= 1'b1;
      else if (mem_rvalid) rd_busy_q <= 1'b0;
      fwd_q <= fwd_take;
      if (fwd_take) fwd_data_q <= hit_data;
    end
  end

  p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH)) else $error("buffer count above depth");

  p_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == K_STORE && !drain) |=> count_q == $past(count_q) + 1'b1)
    else $error("accepted store not counted");

  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !(req_valid && req_ready && req_kind == K_STORE)) |=> count_q == $past(count_q) - 1'b1)
    else $error("written store not removed");

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cand && !starved) |-> (mem_valid && !mem_we))
    else $error("missing load did not get the port");

  p_fwd_nomem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && hit) |-> !(mem_valid && !mem_we))
    else $error("forwarded load went to memory");

  p_fwd_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && req_ready && hit) |=> rsp_valid)
    else $error("forwarded response late");

  p_one_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy_q |-> !(mem_valid && !mem_we))
    else $error("second read while one outstanding");

  p_rsp_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_q && rd_busy_q && mem_rvalid))
    else $error("two responses in one cycle");

  p_lfence_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == K_LFENCE) |-> !rd_busy_q)
    else $error("load fence passed an open read");

  p_sfence_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == K_SFENCE) |-> !mem_valid)
    else $error("store fence passed a buffered store");

  p_mfence_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind[2]) |-> (!mem_valid && !rd_busy_q))
    else $error("full fence passed pending work");

  p_starve_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (starved && !empty) |-> (mem_valid && mem_we))
    else $error("aged store lost the port");

endmodule

// File: tb/test_ordered_store_buffer.sv
`timescale 1ns/1ps
module test_ordered_store_buffer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = 3'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_valid;
  logic        mem_ready;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic        rdy_rand = 1'b1;
  logic        stall_writes = 1'b0;
  bit          rand_mode = 1'b0;
  int          rd_lat = 2;

  int n_chk = 0, n_fail = 0;
  int n_wr = 0, n_rd = 0, n_rsp = 0, n_st = 0, n_hs = 0;
  bit hs_log [64];
  logic [31:0] mem_arr [16];
  logic [31:0] ref_mem [16];
  logic [63:0] exp_wq [$];
  logic [31:0] exp_rq [$];

  bit          rd_busy = 1'b0;
  int          rd_cnt = 0;
  logic [31:0] rd_data = '0;

  always #4 clk = ~clk;

  assign mem_ready = rdy_rand && !(stall_writes && mem_we);

  ordered_store_buffer i_ordered_store_buffer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // memory model and monitor (scoreboard side)
  always @(negedge clk) begin
    if (rd_busy) begin
      if (rd_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd_data;
        rd_busy    = 1'b0;
      end else begin
        rd_cnt--;
        mem_rvalid = 1'b0;
      end
    end else begin
      mem_rvalid = 1'b0;
    end
    rdy_rand = rand_mode ? ($urandom_range(3) != 0) : 1'b1;
    #2;
    if (rst_n) begin
      if (mem_valid && mem_ready) begin
        hs_log[n_hs % 64] = mem_we;
        n_hs++;
        if (mem_we) begin
          n_wr++;
          if (exp_wq.size() == 0) chk(1'b0, "R2 unexpected write", {mem_addr, mem_wdata}, 64'h0);
          else begin
            logic [63:0] e;
            e = exp_wq.pop_front();
            chk({mem_addr, mem_wdata} == e, "R2 write order/content", {mem_addr, mem_wdata}, e);
          end
          mem_arr[mem_addr[5:2]] = mem_wdata;
        end else begin
          n_rd++;
          rd_busy = 1'b1;
          rd_cnt  = rand_mode ? $urandom_range(3) : rd_lat - 1;
          rd_data = mem_arr[mem_addr[5:2]];
        end
      end
      if (rsp_valid) begin
        n_rsp++;
        if (exp_rq.size() == 0) chk(1'b0, "R5 unexpected response", {32'h0, rsp_rdata}, 64'h0);
        else begin
          logic [31:0] e;
          e = exp_rq.pop_front();
          chk(rsp_rdata == e, "R5 load value/order", {32'h0, rsp_rdata}, {32'h0, e});
        end
      end
    end
  end

  // driver: pushes expected items on acceptance
  task automatic issue(input logic [2:0] k, input int idx, input logic [31:0] d,
                       input int maxwait, output bit acc, output int waited);
    acc = 1'b0;
    waited = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = k;
    req_addr  = {26'b0, idx[3:0], 2'b00};
    req_wdata = d;
    forever begin
      #1;
      if (req_ready) begin
        acc = 1'b1;
        if (k == 3'd1) begin
          ref_mem[idx[3:0]] = d;
          exp_wq.push_back({req_addr, d});
          n_st++;
        end else if (k == 3'd0) begin
          exp_rq.push_back(ref_mem[idx[3:0]]);
        end
        break;
      end
      if (maxwait >= 0 && waited >= maxwait) break;
      waited++;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_drained(input int limit);
    for (int c = 0; c < limit; c++) begin
      if (n_wr == n_st && exp_rq.size() == 0) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL all requirements (watchdog): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit acc;
    int w, hs0, rsp0, rd0;
    for (int i = 0; i < 16; i++) begin
      mem_arr[i] = 32'h1000 + i * 17;
      ref_mem[i] = 32'h1000 + i * 17;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    req_kind = 3'd1;
    #1;
    chk(mem_valid == 1'b0, "R10 no memory request", {63'h0, mem_valid}, 64'h0);
    chk(rsp_valid == 1'b0, "R10 no response", {63'h0, rsp_valid}, 64'h0);
    chk(req_ready == 1'b1, "R10 store ready", {63'h0, req_ready}, 64'h1);

    // R3: a missing load passes stores that memory refuses to write
    stall_writes = 1'b1;
    issue(3'd1, 0, 32'hA000_0000, -1, acc, w);
    issue(3'd1, 1, 32'hA000_0001, -1, acc, w);
    issue(3'd1, 2, 32'hA000_0002, -1, acc, w);
    rsp0 = n_rsp;
    issue(3'd0, 5, 32'h0, 3, acc, w);
    chk(acc, "R3 load issued past stores", {63'h0, acc}, 64'h1);
    for (int c = 0; c < 20 && n_rsp == rsp0; c++) @(negedge clk);
    chk(n_rsp == rsp0 + 1, "R3 bypass load answered", 64'(n_rsp), 64'(rsp0 + 1));
    chk(n_wr == 0, "R3 read ahead of writes", 64'(n_wr), 64'h0);

    // R1 and R4: fill buffer, forward youngest
    issue(3'd1, 1, 32'hCAFE_0001, -1, acc, w);
    issue(3'd1, 7, 32'h7777_0007, 4, acc, w);
    chk(!acc, "R1 store stalled when full", {63'h0, acc}, 64'h0);
    rd0 = n_rd;
    issue(3'd0, 1, 32'h0, 2, acc, w);
    chk(acc, "R4 matching load accepted", {63'h0, acc}, 64'h1);
    @(negedge clk);
    #2;
    chk(rsp_valid == 1'b1, "R4 response next cycle", {63'h0, rsp_valid}, 64'h1);
    chk(rsp_rdata == 32'hCAFE_0001, "R4 youngest match", {32'h0, rsp_rdata}, 64'hCAFE_0001);
    issue(3'd0, 0, 32'h0, 2, acc, w);
    repeat (3) @(negedge clk);
    chk(n_rd == rd0, "R4 no memory read", 64'(n_rd), 64'(rd0));
    stall_writes = 1'b0;
    wait_drained(100);
    chk(n_wr == n_st, "R2 all stores written", 64'(n_wr), 64'(n_st));
    issue(3'd1, 7, 32'h7777_0007, 2, acc, w);
    chk(acc, "R1 store accepted after drain", {63'h0, acc}, 64'h1);
    wait_drained(100);

    // R9: aged store takes the port back
    stall_writes = 1'b1;
    issue(3'd1, 3, 32'h3333_0003, -1, acc, w);
    repeat (12) @(negedge clk);
    issue(3'd0, 9, 32'h0, 3, acc, w);
    chk(!acc, "R9 load held behind aged store", {63'h0, acc}, 64'h0);
    hs0 = n_hs;
    stall_writes = 1'b0;
    issue(3'd0, 9, 32'h0, -1, acc, w);
    wait_drained(100);
    chk(hs_log[hs0 % 64] == 1'b1, "R9 aged store first", {63'h0, hs_log[hs0 % 64]}, 64'h1);
    chk(hs_log[(hs0 + 1) % 64] == 1'b0, "R9 load after store", {63'h0, hs_log[(hs0 + 1) % 64]}, 64'h0);

    // R6: load fence waits for an open read
    rd_lat = 6;
    rsp0 = n_rsp;
    issue(3'd0, 4, 32'h0, -1, acc, w);
    issue(3'd2, 0, 32'h0, 3, acc, w);
    chk(!acc, "R6 fence held by open read", {63'h0, acc}, 64'h0);
    issue(3'd2, 0, 32'h0, -1, acc, w);
    chk(n_rsp == rsp0 + 1, "R6 load done before fence", 64'(n_rsp), 64'(rsp0 + 1));

    // R7: store fence waits for an empty buffer
    stall_writes = 1'b1;
    issue(3'd1, 10, 32'h0A0A_000A, -1, acc, w);
    issue(3'd1, 11, 32'h0B0B_000B, -1, acc, w);
    issue(3'd3, 0, 32'h0, 5, acc, w);
    chk(!acc, "R7 fence held by buffered stores", {63'h0, acc}, 64'h0);
    stall_writes = 1'b0;
    issue(3'd3, 0, 32'h0, -1, acc, w);
    chk(n_wr == n_st, "R7 stores written before fence", 64'(n_wr), 64'(n_st));

    // R8: full fence waits for both
    rd_lat = 8;
    rsp0 = n_rsp;
    issue(3'd0, 12, 32'h0, -1, acc, w);
    issue(3'd1, 13, 32'h0D0D_000D, -1, acc, w);
    issue(3'd4, 0, 32'h0, -1, acc, w);
    chk(n_rsp == rsp0 + 1, "R8 read done before full fence", 64'(n_rsp), 64'(rsp0 + 1));
    chk(n_wr == n_st, "R8 store done before full fence", 64'(n_wr), 64'(n_st));
    stall_writes = 1'b1;
    issue(3'd1, 14, 32'h0E0E_000E, -1, acc, w);
    issue(3'd6, 0, 32'h0, 4, acc, w);
    chk(!acc, "R8 kind 6 held by buffered store", {63'h0, acc}, 64'h0);
    stall_writes = 1'b0;
    issue(3'd6, 0, 32'h0, -1, acc, w);
    chk(acc && n_wr == n_st, "R8 kind 6 accepted once empty", 64'(n_wr), 64'(n_st));

    // random mixed traffic
    rd_lat = 2;
    rand_mode = 1'b1;
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom_range(9);
      if (r < 4)      issue(3'd0, $urandom_range(7), 32'h0, -1, acc, w);
      else if (r < 8) issue(3'd1, $urandom_range(7), $urandom, -1, acc, w);
      else            issue(3'($urandom_range(2, 4)), 0, 32'h0, -1, acc, w);
    end
    wait_drained(1000);
    chk(exp_wq.size() == 0, "R2 no store left unwritten", 64'(exp_wq.size()), 64'h0);
    chk(exp_rq.size() == 0, "R5 no load left unanswered", 64'(exp_rq.size()), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule